// File: doc/BRIEF.md
# Locked Command Register Bank

This block is the host-facing register bank of a storage-card controller. It holds the nine registers that make up a command set: command word, argument, byte count, block size, clock divider, clock enable, clock source, timeout and bus width. It also holds a raw event status register, an event mask register and a control register carrying a global interrupt enable. Host and card-side logic share one clock. The block does no card signalling of its own.

The host launches a command by writing the command word with its start bit set. The block then raises a request toward the card-side engine and holds it until the engine returns a one-cycle acknowledge. The same acknowledge copies the nine command-set registers onto a set of outputs facing the engine.

Until the acknowledge arrives, the command set is frozen. Any host write aimed at it is discarded and recorded as a lock-violation event. Events from the card side, and lock violations, collect in the status register. That register is cleared by writing ones to it. A level interrupt is raised whenever an unmasked status bit is set and the global enable is on.

Top module: `cmdreg_bank`

## Requirements
- R1: Writing the command word (address 0) with bit 31 set while no handoff is pending raises `eng_req` after that clock edge. Reading address 0 then returns bit 31 as 1.
- R2: `eng_req`, and bit 31 of the command readback, stay 1 until `eng_ack` pulses. The edge that samples `eng_ack` clears both. An `eng_ack` that arrives while nothing is pending has no effect.
- R3: The edge that accepts a pending handoff copies the nine registers at addresses 0..8 onto `eng_cmd` … `eng_busw`. At no other time do those outputs change.
- R4: While a handoff is pending, a write to any of addresses 0..8 leaves that register unchanged. This includes a second command word carrying the start bit.
- R5: Every write that is discarded under R4 sets status bit 12 (the lock-violation flag).
- R6: A one-cycle pulse on bit n of `ev_pulse` sets status bit n. The card side uses bit 2 for command done, bit 3 for data done, bit 6 for response CRC error and bit 8 for response timeout.
- R7: Writing the status register (address 9) clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits as they are.
- R8: When a set pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: Writes to the status (9), mask (10) and control (11, bit 0 = global enable) registers are accepted even while a handoff is pending.
- R10: `irq` is 1 exactly when some status bit and its mask bit are both 1 and the global enable is 1. It is a level, not a pulse.
- R11: After reset, every register reads 0, `eng_req` is 0, `irq` is 0, and the `eng_*` outputs are 0.
- R12: A command word written with bit 31 clear is stored but starts no handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for host and card side |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 4 | Host read word address |
| rd_data | output | 32 | Combinational read data |
| ev_pulse | input | 17 | Single-cycle event pulses from the card side |
| eng_req | output | 1 | Handoff request toward the engine |
| eng_ack | input | 1 | One-cycle acceptance from the engine |
| eng_cmd | output | 32 | Latched command word |
| eng_arg | output | 32 | Latched argument |
| eng_bytes | output | 32 | Latched byte count |
| eng_blksz | output | 32 | Latched block size |
| eng_div | output | 32 | Latched clock divider |
| eng_clken | output | 32 | Latched clock enable |
| eng_clksrc | output | 32 | Latched clock source |
| eng_tmo | output | 32 | Latched timeout |
| eng_busw | output | 32 | Latched bus width |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are those that need the lock window held open while other traffic passes. The stimulus opens the window by launching a command and then withholding `eng_ack`. While the window is open, the bench walks a write across every protected address, clearing the violation flag after each one. It also drives mask and control writes during the same window. A second hard case is a status write that lands in the same cycle as a set pulse. The bench drives the clearing write and the event pulse on the same clock edge, with a second, already-set bit in the clear mask, so that the set-wins rule and the ordinary clear are seen together.

// File: rtl/cmdreg_pkg.sv
// Package: register map of the locked command register bank.
// Assumes word addressing; the protected set occupies addresses 0..NPROT-1.
package cmdreg_pkg;
    localparam int NPROT    = 9;
    localparam int ADR_CMD  = 0;
    localparam int ADR_ARG  = 1;
    localparam int ADR_BYT  = 2;
    localparam int ADR_BLK  = 3;
    localparam int ADR_DIV  = 4;
    localparam int ADR_CKE  = 5;
    localparam int ADR_CKS  = 6;
    localparam int ADR_TMO  = 7;
    localparam int ADR_BUSW = 8;
    localparam int ADR_STAT = 9;
    localparam int ADR_MASK = 10;
    localparam int ADR_CTRL = 11;
endpackage

// File: rtl/cmdreg_handoff.sv
// Module: request/acknowledge tracker for command handoff.
// Assumes launch is only asserted while idle; ack is a one-cycle pulse.
module cmdreg_handoff (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic ack,
    output logic busy,
    output logic take
);
    // Acceptance happens only while a request is outstanding.
    assign take = ack & busy;

    // Hold busy from launch until acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (launch) busy <= 1'b1;
        else if (take)   busy <= 1'b0;
    end
endmodule

// File: rtl/cmdreg_file.sv
// Module: protected register storage with write lock.
// Assumes protected registers sit at addresses 0..NPROT-1; one write per cycle.
module cmdreg_file #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int NPROT  = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          locked,
    output logic [NPROT-1:0][DATA_W-1:0]  regs,
    output logic                          drop
);
    logic [NPROT-1:0] hit;

    // A write aimed at the protected set while locked is discarded.
    assign drop = (|hit) & locked;

    for (genvar i = 0; i < NPROT; i++) begin : g_reg
        assign hit[i] = wr_en && (wr_addr == ADDR_W'(i));
        // Store host data for register i when unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)                regs[i] <= '0;
            else if (hit[i] && !locked) regs[i] <= wr_data;
        end
    end
endmodule

// File: rtl/cmdreg_snap.sv
// Module: card-side snapshot of the protected register set.
// Assumes take is a one-cycle acceptance strobe.
module cmdreg_snap #(
    parameter int DATA_W = 32,
    parameter int NPROT  = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take,
    input  logic [NPROT-1:0][DATA_W-1:0]  regs,
    output logic [NPROT-1:0][DATA_W-1:0]  snap
);
    // Copy the command set on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n)    snap <= '0;
        else if (take) snap <= regs;
    end
endmodule

// File: rtl/cmdreg_irq.sv
// Module: raw event status, mask, global enable and level interrupt.
// Assumes DATA_W >= STAT_W; set pulses take priority over clearing writes.
module cmdreg_irq #(
    parameter int DATA_W   = 32,
    parameter int STAT_W   = 17,
    parameter int LOCK_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_pulse,
    input  logic              lock_drop,
    input  logic              stat_wr,
    input  logic              mask_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq_en,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    // Merge card events with the lock-violation event.
    always_comb begin
        set_vec           = ev_pulse;
        set_vec[LOCK_BIT] = set_vec[LOCK_BIT] | lock_drop;
    end

    // Clear mask from a status write.
    assign clr_vec = stat_wr ? wr_data[STAT_W-1:0] : '0;

    // Status update: write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Mask and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            irq_en <= 1'b0;
        end else begin
            if (mask_wr) mask   <= wr_data[STAT_W-1:0];
            if (ctrl_wr) irq_en <= wr_data[0];
        end
    end

    // Level interrupt output.
    assign irq = irq_en & (|(status & mask));
endmodule

// File: rtl/cmdreg_bank.sv
// Module: top of the locked command register bank.
// Assumes host and card side share clk; eng_ack is a one-cycle pulse.
module cmdreg_bank #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int STAT_W    = 17,
    parameter int START_BIT = 31,
    parameter int LOCK_BIT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [STAT_W-1:0] ev_pulse,
    output logic              eng_req,
    input  logic              eng_ack,
    output logic [DATA_W-1:0] eng_cmd,
    output logic [DATA_W-1:0] eng_arg,
    output logic [DATA_W-1:0] eng_bytes,
    output logic [DATA_W-1:0] eng_blksz,
    output logic [DATA_W-1:0] eng_div,
    output logic [DATA_W-1:0] eng_clken,
    output logic [DATA_W-1:0] eng_clksrc,
    output logic [DATA_W-1:0] eng_tmo,
    output logic [DATA_W-1:0] eng_busw,
    output logic              irq
);
    import cmdreg_pkg::*;

    logic                         busy;
    logic                         take;
    logic                         launch;
    logic                         drop;
    logic [NPROT-1:0][DATA_W-1:0] prot_regs;
    logic [NPROT-1:0][DATA_W-1:0] snap;
    logic [STAT_W-1:0]            status;
    logic [STAT_W-1:0]            mask;
    logic                         irq_en;
    logic                         stat_wr;
    logic                         mask_wr;
    logic                         ctrl_wr;

    // Decode launch and unprotected register writes.
    assign launch  = wr_en && (wr_addr == ADDR_W'(ADR_CMD)) && wr_data[START_BIT] && !busy;
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(ADR_STAT));
    assign mask_wr = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign eng_req = busy;

    cmdreg_handoff u_hand (
        .clk(clk), .rst_n(rst_n), .launch(launch), .ack(eng_ack),
        .busy(busy), .take(take)
    );

    cmdreg_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPROT(NPROT)) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(busy), .regs(prot_regs), .drop(drop)
    );

    cmdreg_snap #(.DATA_W(DATA_W), .NPROT(NPROT)) u_snap (
        .clk(clk), .rst_n(rst_n), .take(take), .regs(prot_regs), .snap(snap)
    );

    cmdreg_irq #(.DATA_W(DATA_W), .STAT_W(STAT_W), .LOCK_BIT(LOCK_BIT)) u_irq (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .lock_drop(drop),
        .stat_wr(stat_wr), .mask_wr(mask_wr), .ctrl_wr(ctrl_wr),
        .wr_data(wr_data), .status(status), .mask(mask),
        .irq_en(irq_en), .irq(irq)
    );

    // Unpack the snapshot onto the engine-facing outputs.
    assign eng_cmd    = snap[ADR_CMD];
    assign eng_arg    = snap[ADR_ARG];
    assign eng_bytes  = snap[ADR_BYT];
    assign eng_blksz  = snap[ADR_BLK];
    assign eng_div    = snap[ADR_DIV];
    assign eng_clken  = snap[ADR_CKE];
    assign eng_clksrc = snap[ADR_CKS];
    assign eng_tmo    = snap[ADR_TMO];
    assign eng_busw   = snap[ADR_BUSW];

    // Host read multiplexer; the start bit reads back the pending state.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPROT; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = prot_regs[i];
        end
        if (rd_addr == ADDR_W'(ADR_CMD))  rd_data[START_BIT] = busy;
        if (rd_addr == ADDR_W'(ADR_STAT)) rd_data = DATA_W'(status);
        if (rd_addr == ADDR_W'(ADR_MASK)) rd_data = DATA_W'(mask);
        if (rd_addr == ADDR_W'(ADR_CTRL)) rd_data = DATA_W'(irq_en);
    end
endmodule

// File: rtl/cmdreg_bank_chk.sv
// Module: assertion checker for cmdreg_bank, attached by bind.
// Assumes it observes the top's ports and internal register state.
module cmdreg_bank_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int STAT_W   = 17,
    parameter int LOCK_BIT = 12,
    parameter int NPROT    = 9
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [DATA_W-1:0]            wr_data,
    input logic [STAT_W-1:0]            ev_pulse,
    input logic                         eng_req,
    input logic                         eng_ack,
    input logic [NPROT-1:0][DATA_W-1:0] prot_regs,
    input logic [STAT_W-1:0]            status,
    input logic [STAT_W-1:0]            mask,
    input logic                         irq_en,
    input logic                         irq
);
    import cmdreg_pkg::*;

    logic prot_wr;
    logic stat_wr;
    logic mask_wr;
    assign prot_wr = wr_en && (wr_addr < ADDR_W'(NPROT));
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(ADR_STAT));
    assign mask_wr = wr_en && (wr_addr == ADDR_W'(ADR_MASK));

    assert_start_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> eng_req);

    assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack) |=> !eng_req);

    assert_locked_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && prot_wr) |=> (prot_regs == $past(prot_regs)));

    assert_lock_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && prot_wr) |=> status[LOCK_BIT]);

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_pulse) |=> ((status & $past(ev_pulse)) == $past(ev_pulse)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status & $past(wr_data[STAT_W-1:0] & ~ev_pulse)) == '0));

    assert_mask_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(wr_data[STAT_W-1:0])));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask == '0) || !irq_en) |-> !irq);
endmodule

bind cmdreg_bank cmdreg_bank_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W),
    .LOCK_BIT(LOCK_BIT), .NPROT(cmdreg_pkg::NPROT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_pulse(ev_pulse), .eng_req(eng_req),
    .eng_ack(eng_ack), .prot_regs(prot_regs), .status(status),
    .mask(mask), .irq_en(irq_en), .irq(irq)
);

// File: tb/cmdreg_bank_bench.sv
// Bench: directed sweeps over lock window, status bits and interrupt gating.
module cmdreg_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [16:0] ev_pulse = '0;
    logic        eng_req;
    logic        eng_ack = 1'b0;
    logic [31:0] eng_v [9];
    logic        irq;
    int          nchk = 0;
    int          nfail = 0;
    int          cyc = 0;
    logic [31:0] got;

    always #10 clk = ~clk;

    cmdreg_bank u_cmdreg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_pulse(ev_pulse), .eng_req(eng_req), .eng_ack(eng_ack),
        .eng_cmd(eng_v[0]), .eng_arg(eng_v[1]), .eng_bytes(eng_v[2]),
        .eng_blksz(eng_v[3]), .eng_div(eng_v[4]), .eng_clken(eng_v[5]),
        .eng_clksrc(eng_v[6]), .eng_tmo(eng_v[7]), .eng_busw(eng_v[8]),
        .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [31:0] val(input int k);
        return 32'h0A0B_0000 + 32'(k) * 32'h0101;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 4'(a);
        #1;
        d = rd_data;
    endtask

    task automatic ack_pulse();
        @(negedge clk); eng_ack = 1'b1;
        @(negedge clk); eng_ack = 1'b0;
    endtask

    task automatic ev(input logic [16:0] v);
        @(negedge clk); ev_pulse = v;
        @(negedge clk); ev_pulse = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, got); chk("R11 reg reset", got, 32'h0);
        end
        chk("R11 req reset", 32'(eng_req), 32'h0);
        chk("R11 irq reset", 32'(irq), 32'h0);
        for (int i = 0; i < 9; i++) chk("R11 eng reset", eng_v[i], 32'h0);

        // R12: command word without start bit
        wr(0, 32'h0000_0011);
        rd(0, got); chk("R12 stored", got, 32'h0000_0011);
        chk("R12 no req", 32'(eng_req), 32'h0);

        // Load protected set while unlocked
        for (int k = 1; k < 9; k++) begin
            wr(k, val(k));
            rd(k, got); chk("R4 unlocked write", got, val(k));
        end

        // R1: launch
        wr(0, 32'h8000_0042);
        chk("R1 req up", 32'(eng_req), 32'h1);
        rd(0, got); chk("R1 start readback", got, 32'h8000_0042);
        repeat (5) @(negedge clk);
        chk("R2 req holds", 32'(eng_req), 32'h1);

        // R4/R5/R7: sweep every protected address during the lock
        for (int a = 0; a < 9; a++) begin
            wr(a, 32'hDEAD_0000 | 32'(a) | 32'h8000_0000);
            rd(a, got); chk("R4 locked drop", got, (a == 0) ? 32'h8000_0042 : val(a));
            rd(9, got); chk("R5 lock flag", got, 32'h0000_1000);
            wr(9, 32'h0000_1000);
            rd(9, got); chk("R7 flag cleared", got, 32'h0);
            chk("R3 eng quiet", eng_v[a], 32'h0);
        end

        // R9: unprotected writes accepted during lock
        wr(10, 32'h0001_5555);
        rd(10, got); chk("R9 mask in lock", got, 32'h0001_5555);
        wr(11, 32'h1);
        rd(11, got); chk("R9 ctrl in lock", got, 32'h1);
        wr(10, 32'h0); wr(11, 32'h0);
        chk("R2 still pending", 32'(eng_req), 32'h1);

        // R2/R3: acceptance
        ack_pulse();
        chk("R2 req cleared", 32'(eng_req), 32'h0);
        rd(0, got); chk("R2 start cleared", got, 32'h0000_0042);
        chk("R3 snap cmd", eng_v[0], 32'h8000_0042);
        for (int k = 1; k < 9; k++) chk("R3 snap", eng_v[k], val(k));

        // R2/R3: ack while idle has no effect
        wr(1, 32'h5A5A_A5A5);
        ack_pulse();
        chk("R3 idle ack snap", eng_v[1], val(1));
        chk("R2 idle ack req", 32'(eng_req), 32'h0);

        // R6/R7/R10: sweep every status bit
        for (int b = 0; b < 17; b++) begin
            ev(17'(1) << b);
            rd(9, got); chk("R6 event sets", got, 32'(1) << b);
            wr(9, 32'h0);
            rd(9, got); chk("R7 zero write", got, 32'(1) << b);
            wr(11, 32'h1);
            chk("R10 unmasked", 32'(irq), 32'h0);
            wr(10, 32'(1) << ((b + 1) % 17));
            chk("R10 other mask", 32'(irq), 32'h0);
            wr(10, 32'(1) << b);
            chk("R10 asserted", 32'(irq), 32'h1);
            repeat (2) @(negedge clk);
            chk("R10 level", 32'(irq), 32'h1);
            wr(11, 32'h0);
            chk("R10 disabled", 32'(irq), 32'h0);
            wr(9, 32'(1) << b);
            rd(9, got); chk("R7 cleared", got, 32'h0);
            wr(10, 32'h0);
        end

        // R8: set wins over clear in the same cycle
        ev(17'h0_0020);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'h0000_0028; ev_pulse = 17'h0_0008;
        @(negedge clk);
        wr_en = 1'b0; ev_pulse = '0;
        rd(9, got); chk("R8 set wins", got, 32'h0000_0008);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule